// File: doc/BRIEF.md
# Outstanding-Miss Dispatch Unit

This unit sits behind a cache's tag lookup. Each request that the lookup did not satisfy comes here, together with the lookup's view of the line (present, writable). The unit compares the request's block against a small table of outstanding misses and sends it to one of four outcomes: merge into a matching entry as an extra target, allocate a fresh entry, push to the write buffer, or drop. Software prefetches are answered at once on the requester side, because the core never waits for their data.

A target counter is kept for each entry. When an entry's counter reaches the configured maximum, the unit stops taking requests and records which entry filled. The stall lasts until that entry retires. A request that needs a fresh entry while the table is full is also held, with its own stall flag. Entries are freed through a simple retire port. Per-requester event counters for merges, cacheable misses and uncacheable misses can be read through a select port.

Top module: `miss_dispatch`

## Requirements
- R1: A request with `req_uncache` set never matches an entry, even when a valid entry holds the same block. Cacheable requests never match entries that were allocated uncacheable. A block is the address with the low log2(LINE_BYTES) bits cleared, and a match also needs equal secure bits.
- R2: A software prefetch (command 2) that is accepted gets `res_pf_resp`=1. With no match it allocates an entry (`res_kind` 1).
- R3: A software prefetch that matches an entry reports drop (`res_kind` 3). It adds no target and allocates nothing.
- R4: A clean-evict (command 3) that matches an entry is dropped (`res_kind` 3).
- R5: A write-clean (command 5) always goes to the write buffer (`res_kind` 2), whether or not it matches an entry.
- R6: Any other matching request (read 0, write 1, writeback 4) merges (`res_kind` 0), reports the entry index in `res_entry`, and adds one target.
- R7: A fresh entry starts with one target. When a merge brings an entry to MAX_TGT targets, `blocked_targets` rises, `blocked_entry` names that entry and `req_ready` stays low. Retiring that entry clears the stall.
- R8: When nothing matches, clean-evict, writeback, write-clean and uncacheable writes go to the write buffer. Everything else allocates the lowest free entry and reports its index.
- R9: A write (command 1) that allocates while the lookup reports a valid, non-writable line raises `res_clr_readable`. In every other case that flag is 0.
- R10: A request that needs a fresh entry while all entries are valid raises `blocked_entries` in the same cycle and is not accepted (`req_ready`=0). Once an entry retires, the request can be accepted.
- R11: Counters per stat kind (0 merge, 1 cacheable miss, 2 uncacheable miss), per command and per requester are incremented once per accepted request of that kind. A miss is counted whenever nothing matched, whatever the outcome. They are read on `stat_count` through the selects.
- R12: A result appears on `res_*` with `res_valid`=1 in the cycle after acceptance, and only then. After reset the table is empty, no stall flag is set, `req_ready` is 1 and the counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 3 | Command code |
| req_addr | input | ADDR_W | Byte address |
| req_secure | input | 1 | Secure-space bit |
| req_uncache | input | 1 | Uncacheable request |
| req_src | input | SRC_W | Requester ID |
| lookup_valid | input | 1 | Tag lookup found the line valid |
| lookup_writable | input | 1 | Tag lookup found the line writable |
| req_ready | output | 1 | Request accepted this cycle when valid |
| res_valid | output | 1 | Result of the request accepted last cycle |
| res_kind | output | 2 | 0 merge, 1 allocate, 2 write buffer, 3 drop |
| res_entry | output | IDX_W | Entry merged into or allocated |
| res_pf_resp | output | 1 | Immediate prefetch response |
| res_clr_readable | output | 1 | Clear readable bit of the looked-up line |
| blocked_targets | output | 1 | Stalled on a full target list |
| blocked_entry | output | IDX_W | Entry whose target list filled |
| blocked_entries | output | 1 | Request needs an entry but the table is full |
| retire_valid | input | 1 | Free an entry |
| retire_idx | input | IDX_W | Entry to free |
| stat_kind | input | 2 | Counter kind select |
| stat_cmd | input | 3 | Counter command select |
| stat_src | input | SRC_W | Counter requester select |
| stat_count | output | CNT_W | Selected counter value |

## Verification
Some properties are checked on every cycle: at most one entry matches any request, no target counter exceeds its maximum, either stall flag forces `req_ready` low, a line's readable bit is only cleared on an allocation, and uncacheable requests and write-cleans never merge. Other behaviour shows only in the bench's scenarios, because it depends on history held in the table: which entry index is chosen, when the target stall fires after a given sequence of merges and ignored prefetches, whether a retire releases the right stall, and whether every counter matches its own reference count.

// File: rtl/miss_dispatch_pkg.sv
package miss_dispatch_pkg;

  typedef enum logic [2:0] {
    CMD_READ        = 3'd0,
    CMD_WRITE       = 3'd1,
    CMD_SWPF        = 3'd2,
    CMD_CLEAN_EVICT = 3'd3,
    CMD_WRITEBACK   = 3'd4,
    CMD_WRITE_CLEAN = 3'd5,
    CMD_RSVD6       = 3'd6,
    CMD_RSVD7       = 3'd7
  } md_cmd_e;

  typedef enum logic [1:0] {
    RES_MERGE = 2'd0,
    RES_ALLOC = 2'd1,
    RES_WBUF  = 2'd2,
    RES_DROP  = 2'd3
  } md_res_e;

  localparam int N_STAT_KIND = 3;
  localparam int N_CMD       = 8;

  typedef struct packed {
    md_res_e kind;
    logic    pf_resp;
    logic    clr_readable;
    logic    ev_hit;
    logic    ev_miss;
    logic    ev_unc;
  } md_decision_t;

  function automatic logic cmd_is_eviction(input md_cmd_e c);
    return (c == CMD_CLEAN_EVICT) || (c == CMD_WRITEBACK);
  endfunction

  function automatic logic cmd_is_write(input md_cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_WRITEBACK) || (c == CMD_WRITE_CLEAN);
  endfunction

endpackage

// File: rtl/md_classify.sv
module md_classify
  import miss_dispatch_pkg::*;
(
  input  md_cmd_e      cmd,
  input  logic         uncache,
  input  logic         hit_any,
  input  logic         lookup_valid,
  input  logic         lookup_writable,
  output md_decision_t dec
);

  logic is_pf, is_ce, is_wc, to_wbuf_nomatch;

  assign is_pf = (cmd == CMD_SWPF);
  assign is_ce = (cmd == CMD_CLEAN_EVICT);
  assign is_wc = (cmd == CMD_WRITE_CLEAN);
  assign to_wbuf_nomatch = cmd_is_eviction(cmd) || is_wc ||
                           (uncache && cmd_is_write(cmd));

  always_comb begin
    dec = '0;
    dec.pf_resp = is_pf;
    if (hit_any) begin
      if (is_pf || is_ce)   dec.kind = RES_DROP;
      else if (is_wc)       dec.kind = RES_WBUF;
      else                  dec.kind = RES_MERGE;
      dec.ev_hit = !(is_pf || is_ce || is_wc);
    end else begin
      dec.kind    = to_wbuf_nomatch ? RES_WBUF : RES_ALLOC;
      dec.ev_miss = !uncache;
      dec.ev_unc  = uncache;
    end
    dec.clr_readable = (dec.kind == RES_ALLOC) && (cmd == CMD_WRITE) &&
                       lookup_valid && !lookup_writable;
  end

endmodule

// File: rtl/md_entry_table.sv
module md_entry_table #(
  parameter int ADDR_W  = 32,
  parameter int N_ENTRY = 4,
  parameter int MAX_TGT = 4,
  localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
  localparam int TGT_W  = $clog2(MAX_TGT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_block,
  input  logic              lk_secure,
  input  logic              lk_uncache,
  output logic              hit_any,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [TGT_W-1:0]  hit_cnt,
  output logic              full,
  output logic [IDX_W-1:0]  free_idx,
  input  logic              do_alloc,
  input  logic              do_merge,
  input  logic              retire_valid,
  input  logic [IDX_W-1:0]  retire_idx
);

  logic              ent_v   [N_ENTRY];
  logic [ADDR_W-1:0] ent_blk [N_ENTRY];
  logic              ent_sec [N_ENTRY];
  logic              ent_unc [N_ENTRY];
  logic [TGT_W-1:0]  ent_cnt [N_ENTRY];
  logic [N_ENTRY-1:0] v_vec;
  logic [N_ENTRY-1:0] hit_vec;

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v[i]   <= 1'b0;
        ent_blk[i] <= '0;
        ent_sec[i] <= 1'b0;
        ent_unc[i] <= 1'b0;
        ent_cnt[i] <= '0;
      end else if (retire_valid && (retire_idx == IDX_W'(i))) begin
        ent_v[i]   <= 1'b0;
        ent_cnt[i] <= '0;
      end else if (do_alloc && (free_idx == IDX_W'(i))) begin
        ent_v[i]   <= 1'b1;
        ent_blk[i] <= lk_block;
        ent_sec[i] <= lk_secure;
        ent_unc[i] <= lk_uncache;
        ent_cnt[i] <= TGT_W'(1);
      end else if (do_merge && hit_vec[i]) begin
        ent_cnt[i] <= ent_cnt[i] + TGT_W'(1);
      end
    end

    assign v_vec[i]   = ent_v[i];
    assign hit_vec[i] = ent_v[i] && !ent_unc[i] && !lk_uncache &&
                        (ent_blk[i] == lk_block) && (ent_sec[i] == lk_secure);

    // R7: a target counter never grows past the configured maximum
    a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      ent_cnt[i] <= TGT_W'(MAX_TGT));
  end

  assign hit_any = |hit_vec;
  assign full    = &v_vec;

  always_comb begin
    hit_idx = '0;
    hit_cnt = '0;
    for (int i = 0; i < N_ENTRY; i++) begin
      if (hit_vec[i]) begin
        hit_idx = IDX_W'(i);
        hit_cnt = ent_cnt[i];
      end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (!ent_v[i]) free_idx = IDX_W'(i);
    end
  end

  // R1: a block is held by at most one matchable entry
  a_r1_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R10: an allocation only happens while a free slot exists
  a_r10_alloc_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    do_alloc |-> !full);

endmodule

// File: rtl/md_stats.sv
module md_stats
  import miss_dispatch_pkg::*;
#(
  parameter int SRC_W = 2,
  parameter int CNT_W = 16,
  localparam int N_SRC = 1 << SRC_W,
  localparam int N_CTR = N_STAT_KIND * N_CMD * N_SRC,
  localparam int CI_W  = $clog2(N_CTR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_hit,
  input  logic             ev_miss,
  input  logic             ev_unc,
  input  logic [2:0]       ev_cmd,
  input  logic [SRC_W-1:0] ev_src,
  input  logic [1:0]       rd_kind,
  input  logic [2:0]       rd_cmd,
  input  logic [SRC_W-1:0] rd_src,
  output logic [CNT_W-1:0] rd_count
);

  logic [CNT_W-1:0] ctr [N_CTR];

  function automatic logic [CI_W-1:0] ctr_index(input int k, input int c, input int s);
    return CI_W'(k * N_CMD * N_SRC + c * N_SRC + s);
  endfunction

  logic [CI_W-1:0] i_hit, i_miss, i_unc, i_rd;
  assign i_hit  = ctr_index(0, int'(ev_cmd), int'(ev_src));
  assign i_miss = ctr_index(1, int'(ev_cmd), int'(ev_src));
  assign i_unc  = ctr_index(2, int'(ev_cmd), int'(ev_src));
  assign i_rd   = ctr_index(int'(rd_kind), int'(rd_cmd), int'(rd_src));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CTR; i++) ctr[i] <= '0;
    end else begin
      if (ev_hit)  ctr[i_hit]  <= ctr[i_hit]  + CNT_W'(1);
      if (ev_miss) ctr[i_miss] <= ctr[i_miss] + CNT_W'(1);
      if (ev_unc)  ctr[i_unc]  <= ctr[i_unc]  + CNT_W'(1);
    end
  end

  assign rd_count = (int'(rd_kind) < N_STAT_KIND) ? ctr[i_rd] : '0;

  // R11: one request produces at most one counted event
  a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_hit, ev_miss, ev_unc}) <= 1);

endmodule

// File: rtl/miss_dispatch.sv
module miss_dispatch
  import miss_dispatch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int N_ENTRY    = 4,
  parameter int MAX_TGT    = 4,
  parameter int SRC_W      = 2,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_secure,
  input  logic              req_uncache,
  input  logic [SRC_W-1:0]  req_src,
  input  logic              lookup_valid,
  input  logic              lookup_writable,
  output logic              req_ready,
  output logic              res_valid,
  output logic [1:0]        res_kind,
  output logic [IDX_W-1:0]  res_entry,
  output logic              res_pf_resp,
  output logic              res_clr_readable,
  output logic              blocked_targets,
  output logic [IDX_W-1:0]  blocked_entry,
  output logic              blocked_entries,
  input  logic              retire_valid,
  input  logic [IDX_W-1:0]  retire_idx,
  input  logic [1:0]        stat_kind,
  input  logic [2:0]        stat_cmd,
  input  logic [SRC_W-1:0]  stat_src,
  output logic [CNT_W-1:0]  stat_count
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TGT_W = $clog2(MAX_TGT + 1);

  function automatic logic [ADDR_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    return a & ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));
  endfunction

  md_cmd_e          cmd;
  logic [ADDR_W-1:0] blk_addr;
  logic             hit_any, full;
  logic [IDX_W-1:0] hit_idx, free_idx;
  logic [TGT_W-1:0] hit_cnt;
  md_decision_t     dec;

  // named internal events
  logic accept, want_alloc, do_alloc, do_merge, fills_targets, unblock;
  logic             blk_tgt_q;
  logic [IDX_W-1:0] blk_idx_q;

  assign cmd      = md_cmd_e'(req_cmd);
  assign blk_addr = block_of(req_addr);

  md_entry_table #(
    .ADDR_W (ADDR_W),
    .N_ENTRY(N_ENTRY),
    .MAX_TGT(MAX_TGT)
  ) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_block    (blk_addr),
    .lk_secure   (req_secure),
    .lk_uncache  (req_uncache),
    .hit_any     (hit_any),
    .hit_idx     (hit_idx),
    .hit_cnt     (hit_cnt),
    .full        (full),
    .free_idx    (free_idx),
    .do_alloc    (do_alloc),
    .do_merge    (do_merge),
    .retire_valid(retire_valid),
    .retire_idx  (retire_idx)
  );

  md_classify u_class (
    .cmd            (cmd),
    .uncache        (req_uncache),
    .hit_any        (hit_any),
    .lookup_valid   (lookup_valid),
    .lookup_writable(lookup_writable),
    .dec            (dec)
  );

  assign want_alloc      = (dec.kind == RES_ALLOC);
  assign blocked_entries = req_valid && want_alloc && full;
  assign req_ready       = !blk_tgt_q && !(want_alloc && full);
  assign accept          = req_valid && req_ready;
  assign do_alloc        = accept && want_alloc;
  assign do_merge        = accept && (dec.kind == RES_MERGE);
  assign fills_targets   = do_merge && (hit_cnt == TGT_W'(MAX_TGT - 1)) &&
                           !(retire_valid && (retire_idx == hit_idx));
  assign unblock         = blk_tgt_q && retire_valid && (retire_idx == blk_idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_tgt_q <= 1'b0;
      blk_idx_q <= '0;
    end else if (fills_targets) begin
      blk_tgt_q <= 1'b1;
      blk_idx_q <= hit_idx;
    end else if (unblock) begin
      blk_tgt_q <= 1'b0;
      blk_idx_q <= '0;
    end
  end

  assign blocked_targets = blk_tgt_q;
  assign blocked_entry   = blk_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid        <= 1'b0;
      res_kind         <= 2'd0;
      res_entry        <= '0;
      res_pf_resp      <= 1'b0;
      res_clr_readable <= 1'b0;
    end else begin
      res_valid        <= accept;
      res_kind         <= accept ? dec.kind : 2'd0;
      res_entry        <= !accept ? '0 :
                          (dec.kind == RES_MERGE) ? hit_idx :
                          (dec.kind == RES_ALLOC) ? free_idx : '0;
      res_pf_resp      <= accept && dec.pf_resp;
      res_clr_readable <= accept && dec.clr_readable;
    end
  end

  md_stats #(
    .SRC_W(SRC_W),
    .CNT_W(CNT_W)
  ) u_stats (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_hit  (accept && dec.ev_hit),
    .ev_miss (accept && dec.ev_miss),
    .ev_unc  (accept && dec.ev_unc),
    .ev_cmd  (req_cmd),
    .ev_src  (req_src),
    .rd_kind (stat_kind),
    .rd_cmd  (stat_cmd),
    .rd_src  (stat_src),
    .rd_count(stat_count)
  );

  // R1: an uncacheable request never merges
  a_r1_unc_no_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_uncache) |=> (res_kind != RES_MERGE));

  // R2: every accepted software prefetch gets its immediate response
  a_r2_pf_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_cmd == CMD_SWPF)) |=> res_pf_resp);

  // R5: write-clean always reaches the write buffer
  a_r5_wc_to_wbuf: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_cmd == CMD_WRITE_CLEAN)) |=> (res_kind == RES_WBUF));

  // R7: the target stall holds back every request
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_targets |-> !req_ready);

  // R10: the table-full stall holds back the request
  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_entries |-> !req_ready);

  // R9: a readable bit is cleared only alongside an allocation
  a_r9_clr_on_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    res_clr_readable |-> (res_valid && (res_kind == RES_ALLOC)));

  // R12: results come only from an acceptance in the previous cycle
  a_r12_result_timing: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(accept));

endmodule

// File: tb/test_miss_dispatch.sv
`timescale 1ns/1ps
module test_miss_dispatch;

  localparam int ADDR_W = 32, LINE_BYTES = 64, N_ENTRY = 4, MAX_TGT = 4;
  localparam int SRC_W = 2, CNT_W = 16, IDX_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_secure = 1'b0, req_uncache = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SRC_W-1:0] req_src = '0;
  logic lookup_valid = 1'b0, lookup_writable = 1'b0;
  logic req_ready, res_valid, res_pf_resp, res_clr_readable;
  logic [1:0] res_kind;
  logic [IDX_W-1:0] res_entry, blocked_entry;
  logic blocked_targets, blocked_entries;
  logic retire_valid = 1'b0;
  logic [IDX_W-1:0] retire_idx = '0;
  logic [1:0] stat_kind = 2'd0;
  logic [2:0] stat_cmd = 3'd0;
  logic [SRC_W-1:0] stat_src = '0;
  logic [CNT_W-1:0] stat_count;

  always #4 clk = ~clk;

  miss_dispatch #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .N_ENTRY(N_ENTRY),
                  .MAX_TGT(MAX_TGT), .SRC_W(SRC_W), .CNT_W(CNT_W)) i_miss_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_secure(req_secure), .req_uncache(req_uncache),
    .req_src(req_src), .lookup_valid(lookup_valid), .lookup_writable(lookup_writable),
    .req_ready(req_ready), .res_valid(res_valid), .res_kind(res_kind),
    .res_entry(res_entry), .res_pf_resp(res_pf_resp), .res_clr_readable(res_clr_readable),
    .blocked_targets(blocked_targets), .blocked_entry(blocked_entry),
    .blocked_entries(blocked_entries), .retire_valid(retire_valid),
    .retire_idx(retire_idx), .stat_kind(stat_kind), .stat_cmd(stat_cmd),
    .stat_src(stat_src), .stat_count(stat_count));

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  // reference state
  bit m_v [N_ENTRY];
  int m_blk [N_ENTRY];
  bit m_sec [N_ENTRY];
  bit m_unc [N_ENTRY];
  int m_cnt [N_ENTRY];
  bit m_stall = 0;
  int m_stall_idx = 0;
  int m_stat [3][8][4];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit is_evict(input int c); return c == 3 || c == 4; endfunction
  function automatic bit is_wr(input int c);    return c == 1 || c == 4 || c == 5; endfunction
  function automatic bit m_full();
    bit f = 1;
    for (int i = 0; i < N_ENTRY; i++) if (!m_v[i]) f = 0;
    return f;
  endfunction
  function automatic int m_free();
    for (int i = 0; i < N_ENTRY; i++) if (!m_v[i]) return i;
    return 0;
  endfunction

  task automatic send(input int cmd, input int blk, input bit sec, input bit unc,
                      input int src, input bit lv, input bit lw);
    int hidx, kind, eidx;
    bit hit, ready, clr, fullst;
    string tag;
    @(negedge clk);
    req_cmd = 3'(cmd);
    req_addr = ADDR_W'(blk * LINE_BYTES + int'($urandom_range(0, LINE_BYTES - 1)));
    req_secure = sec; req_uncache = unc; req_src = SRC_W'(src);
    lookup_valid = lv; lookup_writable = lw; req_valid = 1'b1;
    hit = 0; hidx = 0;
    for (int i = 0; i < N_ENTRY; i++)
      if (m_v[i] && !m_unc[i] && !unc && m_blk[i] == blk && m_sec[i] == sec) begin
        hit = 1; hidx = i;
      end
    if (hit) kind = (cmd == 2 || cmd == 3) ? 3 : (cmd == 5) ? 2 : 0;
    else kind = (is_evict(cmd) || cmd == 5 || (unc && is_wr(cmd))) ? 2 : 1;
    fullst = m_full();
    ready = !m_stall && !(kind == 1 && fullst);
    clr = (kind == 1) && cmd == 1 && lv && !lw;
    eidx = (kind == 0) ? hidx : (kind == 1) ? m_free() : 0;
    tag = unc ? "R1" : (cmd == 2) ? (hit ? "R3" : "R2") : (cmd == 3 && hit) ? "R4" :
          (cmd == 5) ? "R5" : (kind == 0) ? "R6" : clr ? "R9" : "R8";
    #1;
    chk(blocked_entries == (kind == 1 && fullst), "R10", "blocked_entries",
        int'(blocked_entries), int'(kind == 1 && fullst));
    chk(req_ready == ready, m_stall ? "R7" : "R10", "req_ready", int'(req_ready), int'(ready));
    chk(blocked_targets == m_stall, "R7", "blocked_targets", int'(blocked_targets), int'(m_stall));
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(res_valid == ready, "R12", "res_valid", int'(res_valid), int'(ready));
    if (ready) begin
      chk(res_kind == 2'(kind), tag, "res_kind", int'(res_kind), kind);
      if (kind <= 1) chk(res_entry == IDX_W'(eidx), tag, "res_entry", int'(res_entry), eidx);
      chk(res_pf_resp == (cmd == 2), tag, "res_pf_resp", int'(res_pf_resp), int'(cmd == 2));
      chk(res_clr_readable == clr, "R9", "res_clr_readable", int'(res_clr_readable), int'(clr));
      if (kind == 1) begin
        m_v[eidx] = 1; m_blk[eidx] = blk; m_sec[eidx] = sec; m_unc[eidx] = unc; m_cnt[eidx] = 1;
      end else if (kind == 0) begin
        m_cnt[hidx]++;
        if (m_cnt[hidx] == MAX_TGT) begin m_stall = 1; m_stall_idx = hidx; end
      end
      if (kind == 0) m_stat[0][cmd][src]++;
      else if (!hit) m_stat[unc ? 2 : 1][cmd][src]++;
      if (m_stall) chk(blocked_entry == IDX_W'(m_stall_idx), "R7", "blocked_entry",
                       int'(blocked_entry), m_stall_idx);
    end
  endtask

  task automatic retire(input int idx);
    @(negedge clk);
    retire_valid = 1'b1; retire_idx = IDX_W'(idx);
    @(posedge clk); #1;
    retire_valid = 1'b0;
    m_v[idx] = 0; m_cnt[idx] = 0;
    if (m_stall && m_stall_idx == idx) m_stall = 0;
    chk(blocked_targets == m_stall, "R7", "blocked_targets after retire",
        int'(blocked_targets), int'(m_stall));
  endtask

  task automatic retire_all();
    for (int i = 0; i < N_ENTRY; i++) if (m_v[i]) retire(i);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < N_ENTRY; i++) begin m_v[i] = 0; m_cnt[i] = 0; m_blk[i] = 0; end
    foreach (m_stat[k, c, s]) m_stat[k][c][s] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R12 reset state
    chk(req_ready == 1'b1, "R12", "req_ready after reset", int'(req_ready), 1);
    chk(res_valid == 1'b0, "R12", "res_valid after reset", int'(res_valid), 0);
    chk(blocked_targets == 1'b0, "R12", "blocked_targets after reset", int'(blocked_targets), 0);
    chk(blocked_entries == 1'b0, "R12", "blocked_entries after reset", int'(blocked_entries), 0);
    chk(stat_count == '0, "R12", "counter after reset", int'(stat_count), 0);

    // directed: merges, prefetch and clean-evict ignored, write-clean bypass, R7 stall
    send(0, 10, 0, 0, 1, 0, 0);   // alloc entry 0
    send(0, 10, 0, 0, 1, 0, 0);   // merge, 2 targets
    send(2, 10, 0, 0, 2, 0, 0);   // R3 drop, no target
    send(3, 10, 0, 0, 2, 0, 0);   // R4 drop
    send(5, 10, 0, 0, 3, 0, 0);   // R5 wbuf
    send(0, 10, 1, 0, 0, 0, 0);   // other secure space: alloc entry 1
    send(0, 10, 0, 1, 0, 0, 0);   // R1 uncacheable: alloc entry 2
    send(1, 10, 0, 0, 0, 0, 0);   // merge, 3 targets
    send(4, 10, 0, 0, 3, 0, 0);   // merge, 4 targets -> stall
    send(0, 20, 0, 0, 0, 0, 0);   // held by stall
    retire(0);
    send(1, 30, 0, 0, 1, 1, 0);   // R9 write alloc on valid non-writable
    send(1, 31, 0, 1, 1, 1, 0);   // uncacheable write -> wbuf
    send(3, 32, 0, 0, 1, 0, 0);   // eviction without match -> wbuf
    send(2, 33, 0, 0, 2, 0, 0);   // R2 prefetch alloc, table now full
    send(0, 34, 0, 0, 2, 0, 0);   // R10 held
    send(5, 34, 0, 0, 2, 0, 0);   // write-clean still passes when full
    retire(2);
    send(0, 34, 0, 0, 2, 1, 1);   // fills freed slot
    retire_all();

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int r, cmd;
      bit unc;
      r = int'($urandom_range(0, 99));
      cmd = (r < 30) ? 0 : (r < 50) ? 1 : (r < 62) ? 2 : (r < 74) ? 3 : (r < 86) ? 4 : 5;
      unc = (cmd <= 1) && ($urandom_range(0, 9) == 0);
      send(cmd, int'($urandom_range(0, 5)), bit'($urandom_range(0, 3) == 0), unc,
           int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      if (m_stall) retire(m_stall_idx);
      else if (m_full() || $urandom_range(0, 4) == 0) retire(int'($urandom_range(0, N_ENTRY - 1)));
    end

    // R11 counter readback
    for (int k = 0; k < 3; k++)
      for (int c = 0; c < 6; c++)
        for (int s = 0; s < 4; s++) begin
          @(negedge clk);
          stat_kind = 2'(k); stat_cmd = 3'(c); stat_src = SRC_W'(s);
          #1;
          chk(stat_count == CNT_W'(m_stat[k][c][s]), "R11", "stat_count",
              int'(stat_count), m_stat[k][c][s]);
        end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule